// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns one asynchronous serial input line into received characters. A base-rate tick, shared with other serial logic and produced elsewhere, paces the receiver. Each bit period spans 16 ticks in normal mode or 8 ticks in double-speed mode, so the bit rate doubles without touching the tick source. The receiver waits for a falling edge on the idle line and confirms it is a real start bit. It then collects 5 to 8 data bits, least significant first, checks an optional even or odd parity bit and checks the stop bit.

Each finished character enters a two-entry receive queue together with its own error flags. Software can therefore read one character while the next one is still arriving. If a character finishes while both queue entries are still unread, that character is dropped and the oldest unread entry is marked as overrun. The mode, parity and length inputs are captured when a start edge is seen, so changing them in the middle of a frame has no effect on that frame.

Top module: `uart_os_rx`

## Requirements
- R1: After reset `rd_valid`, `rd_data`, `err_frame`, `err_parity` and `err_overrun` are all 0.
- R2: With `dbl_speed`=0 a bit lasts 16 `smp_tick` pulses; with `dbl_speed`=1 it lasts 8. The value is captured at the start edge, and frames are received correctly in both modes.
- R3: A high-to-low transition on the idle line, seen at a tick, begins a frame. If the start bit votes high at its middle, the receiver goes back to idle and no character is produced.
- R4: Each bit value is the majority of three consecutive tick samples at the middle of the bit (tick indices 7, 8, 9 of 16, or 3, 4, 5 of 8). One wrong sample among them does not change the received bit.
- R5: `data_len` selects 5 + `data_len` data bits (0 gives 5, 3 gives 8). Bits arrive LSB first. `rd_data` holds the character right-aligned, and its unused upper bits are 0.
- R6: `par_mode` 2'b0x means no parity bit, 2'b10 means even parity and 2'b11 means odd parity. A parity bit that does not match sets `err_parity` for that character.
- R7: A stop bit sampled low sets `err_frame` for that character. The data is still delivered.
- R8: The receive queue holds two characters in arrival order. `rd_data` and the flags show the oldest unread character while `rd_valid` is 1. A one-cycle `rd_strobe` pulse removes that character. The head stays unchanged until it is read.
- R9: A character that completes while two are unread is discarded, and `err_overrun` is set on the oldest unread entry. Later entries carry `err_overrun`=0.
- R10: `err_frame` and `err_parity` are stored per entry and read back with their own character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | One-cycle base-rate sampling pulse |
| rx_line | input | 1 | Serial input line, idle high |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| par_mode | input | 2 | 0x none, 10 even, 11 odd |
| data_len | input | 2 | Data bits minus 5 |
| rd_strobe | input | 1 | Removes the head character |
| rd_data | output | 8 | Head character, right-aligned |
| rd_valid | output | 1 | Queue holds at least one character |
| err_frame | output | 1 | Head character had a low stop bit |
| err_overrun | output | 1 | A character was lost behind the head |
| err_parity | output | 1 | Head character failed its parity check |

## Verification
The input line passes through two synchronizer flops before the tick-driven state machine sees it. A character is therefore pushed into the queue one clock after the tick that takes the third middle sample of the stop bit, about half a bit after the stop bit begins. That is at most a few dozen clocks once the line has reached the stop level. The bench holds the line idle for two full bit periods after each stop bit before it samples any output, so every character is certainly present, and it reads the queue only at falling clock edges. A `rd_strobe` pulse takes effect at the next rising edge, so the new head is checked one clock after the strobe is released.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   localparam int CHAR_W = 8;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_PAR   = 3'd3,
      RX_STOP  = 3'd4
   } rx_state_t;

   typedef struct packed {
      logic [CHAR_W-1:0] data;
      logic              fe;
      logic              pe;
   } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("uart_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= INIT;
         end else begin
            if (s == 0) begin
               chain[s] <= d_in;
            end else begin
               chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   end

   assign d_out = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int OSR_NORM = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx_s,
   input  logic       dbl_speed,
   input  logic [1:0] par_mode,
   input  logic [1:0] data_len,
   output logic       push,
   output rx_char_t   push_char,
   output rx_state_t  state_o
);

   localparam int CW = $clog2(OSR_NORM);
   localparam int BW = $clog2(CHAR_W);
   localparam logic [CW-1:0] LIM_N = CW'(OSR_NORM - 1);
   localparam logic [CW-1:0] LIM_D = CW'(OSR_NORM/2 - 1);
   localparam logic [CW-1:0] MID_N = CW'(OSR_NORM/2);
   localparam logic [CW-1:0] MID_D = CW'(OSR_NORM/4);
   localparam logic [CW-1:0] ONE   = CW'(1);

   if (OSR_NORM < 8 || (OSR_NORM % 4) != 0) begin : g_bad_osr
      $error("uart_rx_frame: OSR_NORM must be a multiple of 4 and at least 8");
   end
   if (CHAR_W != 8) begin : g_bad_width
      $error("uart_rx_frame: character width must be 8");
   end

   rx_state_t         state;
   logic [CW-1:0]     cnt;
   logic [1:0]        win;
   logic              dbl_l;
   logic [1:0]        par_l;
   logic [1:0]        len_l;
   logic [CHAR_W-1:0] shreg;
   logic [BW-1:0]     bit_idx;
   logic              par_acc;
   logic              par_bad;
   logic              rx_prev;

   logic [CW-1:0]     lim;
   logic [CW-1:0]     mid;
   logic              in_win;
   logic              vote_now;
   logic              last_tick;
   logic              vote;
   logic [BW-1:0]     last_idx;
   logic [CHAR_W-1:0] aligned;

   always_comb begin
      lim       = dbl_l ? LIM_D : LIM_N;
      mid       = dbl_l ? MID_D : MID_N;
      in_win    = (cnt == mid - ONE) || (cnt == mid) || (cnt == mid + ONE);
      vote_now  = (cnt == mid + ONE);
      last_tick = (cnt == lim);
      vote      = (win[1] & win[0]) | (win[1] & rx_s) | (win[0] & rx_s);
      last_idx  = BW'({1'b0, len_l}) + BW'(4);
      aligned   = shreg >> (2'd3 - len_l);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         cnt       <= '0;
         win       <= '0;
         dbl_l     <= 1'b0;
         par_l     <= '0;
         len_l     <= '0;
         shreg     <= '0;
         bit_idx   <= '0;
         par_acc   <= 1'b0;
         par_bad   <= 1'b0;
         rx_prev   <= 1'b1;
         push      <= 1'b0;
         push_char <= '0;
      end else begin
         push <= 1'b0;
         if (tick) begin
            rx_prev <= rx_s;
            if (state != RX_IDLE) begin
               cnt <= last_tick ? '0 : cnt + ONE;
               if (in_win) begin
                  win <= {win[0], rx_s};
               end
            end
            case (state)
               RX_IDLE: begin
                  if (rx_prev && !rx_s) begin
                     state   <= RX_START;
                     cnt     <= ONE;
                     dbl_l   <= dbl_speed;
                     par_l   <= par_mode;
                     len_l   <= data_len;
                     par_acc <= 1'b0;
                     par_bad <= 1'b0;
                     bit_idx <= '0;
                  end
               end
               RX_START: begin
                  if (vote_now && vote) begin
                     state <= RX_IDLE;
                  end else if (last_tick) begin
                     state <= RX_DATA;
                  end
               end
               RX_DATA: begin
                  if (vote_now) begin
                     shreg   <= {vote, shreg[CHAR_W-1:1]};
                     par_acc <= par_acc ^ vote;
                  end
                  if (last_tick) begin
                     if (bit_idx == last_idx) begin
                        state <= par_l[1] ? RX_PAR : RX_STOP;
                     end else begin
                        bit_idx <= bit_idx + BW'(1);
                     end
                  end
               end
               RX_PAR: begin
                  if (vote_now) begin
                     par_bad <= par_acc ^ vote ^ par_l[0];
                  end
                  if (last_tick) begin
                     state <= RX_STOP;
                  end
               end
               RX_STOP: begin
                  if (vote_now) begin
                     push           <= 1'b1;
                     push_char.data <= aligned;
                     push_char.fe   <= !vote;
                     push_char.pe   <= par_bad;
                     state          <= RX_IDLE;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   assign state_o = state;

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 2,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int NW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  rx_char_t      push_char,
   input  logic          rd_req,
   output rx_char_t      head_char,
   output logic          head_ovr,
   output logic          valid,
   output logic [NW-1:0] count
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_rx_buf: DEPTH must be at least 2");
   end

   localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
   localparam logic [NW-1:0] CNT_FULL = NW'(DEPTH);

   rx_char_t        mem  [DEPTH];
   logic [DEPTH-1:0] ovrf;
   logic [PW-1:0]   rd_ptr;
   logic [PW-1:0]   wr_ptr;
   logic            pop;
   logic            push_ok;
   logic            ovr_set;

   always_comb begin
      pop     = rd_req && (count != '0);
      push_ok = push && ((count != CNT_FULL) || pop);
      ovr_set = push && (count == CNT_FULL) && !pop;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[g]  <= '0;
            ovrf[g] <= 1'b0;
         end else if (push_ok && (wr_ptr == PW'(g))) begin
            mem[g]  <= push_char;
            ovrf[g] <= 1'b0;
         end else if (ovr_set && (rd_ptr == PW'(g))) begin
            ovrf[g] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (pop) begin
            rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PW'(1);
         end
         if (push_ok) begin
            wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PW'(1);
         end
         case ({push_ok, pop})
            2'b10:   count <= count + NW'(1);
            2'b01:   count <= count - NW'(1);
            default: count <= count;
         endcase
      end
   end

   assign valid     = (count != '0);
   assign head_char = mem[rd_ptr];
   assign head_ovr  = ovrf[rd_ptr];

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
   import uart_rx_pkg::*;
#(
   parameter int OSR_NORM    = 16,
   parameter int BUF_DEPTH   = 2,
   parameter int SYNC_STAGES = 2,
   localparam int NW         = $clog2(BUF_DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp_tick,
   input  logic       rx_line,
   input  logic       dbl_speed,
   input  logic [1:0] par_mode,
   input  logic [1:0] data_len,
   input  logic       rd_strobe,
   output logic [7:0] rd_data,
   output logic       rd_valid,
   output logic       err_frame,
   output logic       err_overrun,
   output logic       err_parity
);

   logic          rx_s;
   logic          frm_push;
   rx_char_t      frm_char;
   rx_state_t     frm_state;
   rx_char_t      head_char;
   logic          head_ovr;
   logic          buf_valid;
   logic [NW-1:0] fifo_count;

   uart_rx_sync #(
      .STAGES (SYNC_STAGES),
      .INIT   (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_line),
      .d_out (rx_s)
   );

   uart_rx_frame #(
      .OSR_NORM (OSR_NORM)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (smp_tick),
      .rx_s      (rx_s),
      .dbl_speed (dbl_speed),
      .par_mode  (par_mode),
      .data_len  (data_len),
      .push      (frm_push),
      .push_char (frm_char),
      .state_o   (frm_state)
   );

   uart_rx_buf #(
      .DEPTH (BUF_DEPTH)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (frm_push),
      .push_char (frm_char),
      .rd_req    (rd_strobe),
      .head_char (head_char),
      .head_ovr  (head_ovr),
      .valid     (buf_valid),
      .count     (fifo_count)
   );

   assign rd_valid    = buf_valid;
   assign rd_data     = buf_valid ? head_char.data : '0;
   assign err_frame   = buf_valid & head_char.fe;
   assign err_parity  = buf_valid & head_char.pe;
   assign err_overrun = buf_valid & head_ovr;

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
   parameter int DEPTH = 2,
   parameter int NW    = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_tick,
   input logic          rd_strobe,
   input logic          rd_valid,
   input logic [7:0]    rd_data,
   input logic          err_overrun,
   input logic [2:0]    fsm_state,
   input logic          push,
   input logic [NW-1:0] fifo_count
);

   // R2: the frame state machine only advances on a sampling tick
   p_state_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_tick |=> $stable(fsm_state));

   // R8: an unread head stays put
   p_head_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_strobe) |=> (rd_valid && $stable(rd_data)));

   // R8: the queue never holds more than its depth
   p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= NW'(DEPTH));

   // R8: reading the last entry empties the queue
   p_pop_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_strobe && fifo_count == NW'(1) && !push) |=> !rd_valid);

   // R9: overrun appears only when the queue was full
   p_ovr_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_overrun) |-> ($past(fifo_count) == NW'(DEPTH)));

   // R7: a character is handed over as the stop bit closes the frame
   p_push_ends_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (fsm_state == 3'd0));

endmodule

bind uart_os_rx uart_os_rx_chk #(
   .DEPTH (BUF_DEPTH),
   .NW    (NW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_tick    (smp_tick),
   .rd_strobe   (rd_strobe),
   .rd_valid    (rd_valid),
   .rd_data     (rd_data),
   .err_overrun (err_overrun),
   .fsm_state   (frm_state),
   .push        (frm_push),
   .fifo_count  (fifo_count)
);

// File: tb/uart_os_rx_tb.sv
`timescale 1ns/1ps
module uart_os_rx_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_tick = 1'b0;
   logic       rx_line = 1'b1;
   logic       dbl_speed = 1'b0;
   logic [1:0] par_mode = 2'b00;
   logic [1:0] data_len = 2'd3;
   logic       rd_strobe = 1'b0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       err_frame;
   logic       err_overrun;
   logic       err_parity;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   localparam int TICK_DIV = 4;

   uart_os_rx u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_tick    (smp_tick),
      .rx_line     (rx_line),
      .dbl_speed   (dbl_speed),
      .par_mode    (par_mode),
      .data_len    (data_len),
      .rd_strobe   (rd_strobe),
      .rd_data     (rd_data),
      .rd_valid    (rd_valid),
      .err_frame   (err_frame),
      .err_overrun (err_overrun),
      .err_parity  (err_parity)
   );

   always #5 clk = ~clk;

   initial begin
      forever begin
         repeat (TICK_DIV - 1) @(negedge clk);
         smp_tick = 1'b1;
         @(negedge clk);
         smp_tick = 1'b0;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic int bit_clks();
      return (dbl_speed ? 8 : 16) * TICK_DIV;
   endfunction

   task automatic drive_bit(input logic v, input bit glitch);
      if (glitch) begin
         repeat (bit_clks()/2 - 2) @(negedge clk);
         rx_line = ~v;
         repeat (TICK_DIV) @(negedge clk);
         rx_line = v;
         repeat (bit_clks() - bit_clks()/2 + 2 - TICK_DIV) @(negedge clk);
      end else begin
         repeat (bit_clks()) @(negedge clk);
      end
   endtask

   // pmode: 0x none, 10 even, 11 odd; glitch_at = data bit index to disturb, -1 none
   task automatic send(input logic [7:0] d, input logic [1:0] len, input logic [1:0] pmode,
                       input bit flip_par, input logic stop_v, input bit dbl, input int glitch_at);
      int nb;
      logic p;
      @(negedge clk);
      data_len  = len;
      par_mode  = pmode;
      dbl_speed = dbl;
      nb = 5 + int'(len);
      rx_line = 1'b0;
      drive_bit(1'b0, 1'b0);
      p = 1'b0;
      for (int i = 0; i < nb; i++) begin
         rx_line = d[i];
         p = p ^ d[i];
         drive_bit(d[i], glitch_at == i);
      end
      if (pmode[1]) begin
         rx_line = p ^ pmode[0] ^ flip_par;
         drive_bit(rx_line, 1'b0);
      end
      rx_line = stop_v;
      drive_bit(stop_v, 1'b0);
      rx_line = 1'b1;
      repeat (2 * bit_clks()) @(negedge clk);
   endtask

   task automatic pop();
      @(negedge clk);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic expect_head(input string tag, input logic [7:0] d,
                              input bit fe, input bit pe, input bit ov);
      check({tag, " valid"}, int'(rd_valid), 1);
      check({tag, " data"}, int'(rd_data), int'(d));
      check({tag, " frame"}, int'(err_frame), int'(fe));
      check({tag, " parity"}, int'(err_parity), int'(pe));
      check({tag, " overrun"}, int'(err_overrun), int'(ov));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 valid", int'(rd_valid), 0);
      check("R1 data", int'(rd_data), 0);
      check("R1 flags", int'({err_frame, err_parity, err_overrun}), 0);
   endtask

   task automatic t_normal();
      send(8'hA5, 2'd3, 2'b00, 1'b0, 1'b1, 1'b0, -1);
      expect_head("R2 normal 8N1", 8'hA5, 0, 0, 0);
      pop();
      check("R8 empty after read", int'(rd_valid), 0);
   endtask

   task automatic t_double();
      send(8'h3C, 2'd3, 2'b10, 1'b0, 1'b1, 1'b1, -1);
      expect_head("R2 double speed", 8'h3C, 0, 0, 0);
      pop();
      send(8'hC3, 2'd3, 2'b00, 1'b0, 1'b1, 1'b0, -1);
      expect_head("R2 back to normal", 8'hC3, 0, 0, 0);
      pop();
   endtask

   task automatic t_false_start();
      @(negedge clk);
      dbl_speed = 1'b0;
      rx_line = 1'b0;
      repeat (3 * TICK_DIV) @(negedge clk);
      rx_line = 1'b1;
      repeat (3 * bit_clks()) @(negedge clk);
      check("R3 false start ignored", int'(rd_valid), 0);
   endtask

   task automatic t_glitch();
      send(8'h55, 2'd3, 2'b00, 1'b0, 1'b1, 1'b0, 2);
      expect_head("R4 majority vote", 8'h55, 0, 0, 0);
      pop();
   endtask

   task automatic t_lengths();
      send(8'h1B, 2'd0, 2'b00, 1'b0, 1'b1, 1'b0, -1);
      expect_head("R5 five bits", 8'h1B, 0, 0, 0);
      pop();
      send(8'h5A, 2'd2, 2'b11, 1'b0, 1'b1, 1'b1, -1);
      expect_head("R5 seven bits odd", 8'h5A, 0, 0, 0);
      pop();
   endtask

   task automatic t_parity();
      send(8'h71, 2'd3, 2'b10, 1'b1, 1'b1, 1'b0, -1);
      expect_head("R6 even mismatch", 8'h71, 0, 1, 0);
      pop();
      send(8'h71, 2'd3, 2'b11, 1'b1, 1'b1, 1'b0, -1);
      expect_head("R6 odd mismatch", 8'h71, 0, 1, 0);
      pop();
      send(8'h70, 2'd3, 2'b11, 1'b0, 1'b1, 1'b0, -1);
      expect_head("R6 odd ok", 8'h70, 0, 0, 0);
      pop();
   endtask

   task automatic t_frame_err();
      send(8'h0F, 2'd3, 2'b00, 1'b0, 1'b0, 1'b0, -1);
      expect_head("R7 low stop", 8'h0F, 1, 0, 0);
      pop();
   endtask

   task automatic t_per_entry();
      send(8'h81, 2'd3, 2'b10, 1'b1, 1'b0, 1'b0, -1);
      send(8'h42, 2'd3, 2'b10, 1'b0, 1'b1, 1'b0, -1);
      expect_head("R10 first entry", 8'h81, 1, 1, 0);
      pop();
      expect_head("R10 second entry", 8'h42, 0, 0, 0);
      pop();
   endtask

   task automatic t_overrun();
      send(8'h11, 2'd3, 2'b00, 1'b0, 1'b1, 1'b0, -1);
      send(8'h22, 2'd3, 2'b00, 1'b0, 1'b1, 1'b0, -1);
      expect_head("R8 oldest first", 8'h11, 0, 0, 0);
      send(8'h33, 2'd3, 2'b00, 1'b0, 1'b1, 1'b0, -1);
      expect_head("R9 overrun on oldest", 8'h11, 0, 0, 1);
      pop();
      expect_head("R9 next entry clean", 8'h22, 0, 0, 0);
      pop();
      check("R9 third discarded", int'(rd_valid), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_normal();
      t_double();
      t_false_start();
      t_glitch();
      t_lengths();
      t_parity();
      t_frame_err();
      t_per_entry();
      t_overrun();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule